// File: doc/BRIEF.md
# External Bus Strobe Sequencer

This block times the address-latch and program-fetch read strobes of a small 8-bit controller core whose external memory bus carries low address and data on the same wires. It runs from the oscillator clock and divides each machine cycle into a fixed number of phases. In an ordinary cycle it gives two address-latch pulses and, when code comes from external memory, two active-low program-fetch strobes. A machine cycle that carries an external data-memory access loses its second latch pulse and both fetch strobes. The bus is then free for the data transfer.

A latch-off control can stop the free-running address-latch pulses. The pin then rests high, and it pulses only in cycles that perform a data access. External-execution mode overrides this control. The block also conditions the raw reset pin. It synchronizes the pin and accepts a reset only after the pin has stayed high for two whole machine cycles. While that qualified reset is asserted, the block drives the strobes to their rest levels and holds the phase at zero.

Top module: `bus_strobe_seq`

## Requirements
- R1: The phase output counts 0,1,...,11 and then wraps to 0, so one machine cycle lasts 12 oscillator clocks.
- R2: In a cycle without a data access and with latch-off inactive, `ale` is high during phases 0,1 and 6,7 and low during all other phases. This gives two pulses per machine cycle, one every six clocks.
- R3: When the cycle was started with `ext_exec`=1 and no data access, `psen_n` is low during phases 3,4,5 and 9,10,11. With `ext_exec`=0, `psen_n` stays high for the whole cycle.
- R4: In a cycle started with `data_req`=1, the `ale` pulse at phases 6,7 is omitted and `psen_n` stays high for the whole cycle. The pulse at phases 0,1 is kept.
- R5: `data_req`, `latch_off` and `ext_exec` are sampled on the clock edge that enters phase 0, and they govern that entire machine cycle. A change that arrives later in the cycle has no effect on the strobes until the next cycle.
- R6: With `latch_off`=1 and `ext_exec`=0, `ale` is held high for the whole of a cycle without a data access. In a data-access cycle it is high only at phases 0,1 and low at phases 2 to 11.
- R7: With `ext_exec`=1, `latch_off` has no effect. The strobes are the same as with `latch_off`=0.
- R8: `rst_pin` passes through two synchronizing flops. `sync_rst` rises on the 26th clock edge after `rst_pin` goes high and stays high, which is 24 clocks of synchronized high. Any low sample restarts the count, so a shorter high pulse never asserts `sync_rst`.
- R9: After `rst_pin` falls, `sync_rst` stays high for two more edges and falls on the third. The machine cycle then starts at phase 0, and phase 1 follows on the next edge.
- R10: While `sync_rst` is high, `phase` is 0 and both `ale` and `psen_n` are high.
- R11: Outside reset, `ale` high and `psen_n` low never occur in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin | input | 1 | Raw reset pin, active high, asynchronous to nothing in particular |
| ext_exec | input | 1 | Code is fetched from external memory |
| latch_off | input | 1 | Stop free-running address-latch pulses |
| data_req | input | 1 | This machine cycle performs an external data-memory access |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | Program-fetch read strobe, active low |
| phase | output | 4 | Current phase within the machine cycle |
| sync_rst | output | 1 | Qualified synchronous reset, active high |

## Verification
Whole machine cycles are run with the eight combinations of the data-access request, latch-off and external execution that matter. Each pattern isolates one behaviour: the second latch pulse versus its omission, fetch strobes present versus suppressed, a pin held high versus pulsing, and latch-off honoured versus overridden. A cycle whose inputs change at phase 2 separates sampling at the cycle boundary from live decoding. On the reset pin, a 20-clock pulse, a restart after a short low and a held level separate a qualification count that clears from one that only accumulates. Counting edges exactly to assertion and release pins down the latency of the two synchronizer flops.

// File: rtl/bus_strobe_pkg.sv
package bus_strobe_pkg;

  // Attributes latched at the start of each machine cycle
  typedef struct packed {
    logic data;       // external data-memory access in this cycle
    logic latch_off;  // latch-off in force (already cleared by external execution)
    logic ext;        // code fetched from external memory
  } cyc_attr_t;

endpackage

// File: rtl/bus_rst_qual.sv
module bus_rst_qual #(
  parameter int QUAL_CLKS = 24
) (
  input  logic clk,
  input  logic arst_n,
  input  logic rst_pin,
  output logic sync_rst
);
  localparam int CNT_W = $clog2(QUAL_CLKS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(QUAL_CLKS);

  logic             s1_q, s2_q;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             rst_nxt;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= rst_pin;
      s2_q <= s1_q;
    end
  end

  always_comb begin
    if (!s2_q)               cnt_nxt = '0;
    else if (cnt_q != CNT_MAX) cnt_nxt = cnt_q + CNT_W'(1);
    else                     cnt_nxt = cnt_q;
    rst_nxt = (cnt_nxt == CNT_MAX);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q    <= '0;
      sync_rst <= 1'b0;
    end else begin
      cnt_q    <= cnt_nxt;
      sync_rst <= rst_nxt;
    end
  end
endmodule

// File: rtl/bus_phase_gen.sv
module bus_phase_gen
  import bus_strobe_pkg::*;
#(
  parameter int CYC_LEN = 12
) (
  input  logic                       clk,
  input  logic                       arst_n,
  input  logic                       sync_rst,
  input  logic                       data_req,
  input  logic                       latch_off,
  input  logic                       ext_exec,
  output logic [$clog2(CYC_LEN)-1:0] phase,
  output cyc_attr_t                  attr
);
  localparam int PH_W = $clog2(CYC_LEN);
  localparam logic [PH_W-1:0] LAST = PH_W'(CYC_LEN - 1);

  logic [PH_W-1:0] ph_q, ph_nxt;
  logic            attr_en;
  cyc_attr_t       attr_nxt;

  always_comb begin
    if (sync_rst)          ph_nxt = '0;
    else if (ph_q == LAST) ph_nxt = '0;
    else                   ph_nxt = ph_q + PH_W'(1);
    attr_en            = (ph_nxt == '0);
    attr_nxt.data      = data_req;
    attr_nxt.latch_off = latch_off & ~ext_exec;
    attr_nxt.ext       = ext_exec;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ph_q <= '0;
      attr <= '0;
    end else begin
      ph_q <= ph_nxt;
      if (attr_en) attr <= attr_nxt;
    end
  end

  // the register may take one more step on the edge reset arrives
  assign phase = sync_rst ? '0 : ph_q;
endmodule

// File: rtl/bus_strobe_dec.sv
module bus_strobe_dec
  import bus_strobe_pkg::*;
#(
  parameter int CYC_LEN  = 12,
  parameter int ALE_W    = 2,
  parameter int PSEN_W   = 3,
  parameter int PSEN_OFF = 3
) (
  input  logic                       in_rst,
  input  logic [$clog2(CYC_LEN)-1:0] phase,
  input  cyc_attr_t                  attr,
  output logic                       ale,
  output logic                       psen_n
);
  localparam int PH_W = $clog2(CYC_LEN);
  localparam int HALF = CYC_LEN / 2;
  localparam int BW   = PH_W + 1;
  localparam logic [BW-1:0] A0_LO = '0;
  localparam logic [BW-1:0] A0_HI = BW'(ALE_W);
  localparam logic [BW-1:0] A1_LO = BW'(HALF);
  localparam logic [BW-1:0] A1_HI = BW'(HALF + ALE_W);
  localparam logic [BW-1:0] P0_LO = BW'(PSEN_OFF);
  localparam logic [BW-1:0] P0_HI = BW'(PSEN_OFF + PSEN_W);
  localparam logic [BW-1:0] P1_LO = BW'(HALF + PSEN_OFF);
  localparam logic [BW-1:0] P1_HI = BW'(HALF + PSEN_OFF + PSEN_W);

  function automatic logic in_win(input logic [BW-1:0] p,
                                  input logic [BW-1:0] lo,
                                  input logic [BW-1:0] hi);
    return (p >= lo) && (p < hi);
  endfunction

  logic [BW-1:0] ph_x;
  logic win_a, win_b, fetch_win;

  always_comb begin
    ph_x      = {1'b0, phase};
    win_a     = in_win(ph_x, A0_LO, A0_HI);
    win_b     = in_win(ph_x, A1_LO, A1_HI);
    fetch_win = in_win(ph_x, P0_LO, P0_HI) | in_win(ph_x, P1_LO, P1_HI);

    if (in_rst)              ale = 1'b1;
    else if (attr.latch_off) ale = attr.data ? win_a : 1'b1;
    else                     ale = win_a | (win_b & ~attr.data);

    psen_n = in_rst | ~(attr.ext & ~attr.data & fetch_win);
  end
endmodule

// File: rtl/bus_strobe_seq.sv
module bus_strobe_seq
  import bus_strobe_pkg::*;
#(
  parameter int CYC_LEN     = 12,
  parameter int QUAL_CYCLES = 2,
  parameter int ALE_W       = 2,
  parameter int PSEN_W      = 3,
  parameter int PSEN_OFF    = 3
) (
  input  logic                       clk,
  input  logic                       arst_n,
  input  logic                       rst_pin,
  input  logic                       ext_exec,
  input  logic                       latch_off,
  input  logic                       data_req,
  output logic                       ale,
  output logic                       psen_n,
  output logic [$clog2(CYC_LEN)-1:0] phase,
  output logic                       sync_rst
);
  localparam int QUAL_CLKS = QUAL_CYCLES * CYC_LEN;

  cyc_attr_t attr;

  bus_rst_qual #(.QUAL_CLKS(QUAL_CLKS)) u_rst (
    .clk      (clk),
    .arst_n   (arst_n),
    .rst_pin  (rst_pin),
    .sync_rst (sync_rst)
  );

  bus_phase_gen #(.CYC_LEN(CYC_LEN)) u_phase (
    .clk       (clk),
    .arst_n    (arst_n),
    .sync_rst  (sync_rst),
    .data_req  (data_req),
    .latch_off (latch_off),
    .ext_exec  (ext_exec),
    .phase     (phase),
    .attr      (attr)
  );

  bus_strobe_dec #(
    .CYC_LEN (CYC_LEN),
    .ALE_W   (ALE_W),
    .PSEN_W  (PSEN_W),
    .PSEN_OFF(PSEN_OFF)
  ) u_dec (
    .in_rst (sync_rst),
    .phase  (phase),
    .attr   (attr),
    .ale    (ale),
    .psen_n (psen_n)
  );
endmodule

// File: rtl/bus_strobe_seq_chk.sv
module bus_strobe_seq_chk #(
  parameter int CYC_LEN     = 12,
  parameter int QUAL_CYCLES = 2,
  parameter int PSEN_W      = 3,
  parameter int PSEN_OFF    = 3
) (
  input logic                       clk,
  input logic                       arst_n,
  input logic                       rst_pin,
  input logic                       ale,
  input logic                       psen_n,
  input logic [$clog2(CYC_LEN)-1:0] phase,
  input logic                       sync_rst
);
  localparam int PH_W      = $clog2(CYC_LEN);
  localparam int HALF      = CYC_LEN / 2;
  localparam int QUAL_CLKS = QUAL_CYCLES * CYC_LEN;
  localparam int HC_W      = $clog2(QUAL_CLKS + 3);
  localparam logic [HC_W-1:0] HC_MAX = HC_W'(QUAL_CLKS + 2);

  // consecutive clocks the raw pin has been high
  logic [HC_W-1:0] hi_cnt;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)              hi_cnt <= '0;
    else if (!rst_pin)        hi_cnt <= '0;
    else if (hi_cnt != HC_MAX) hi_cnt <= hi_cnt + HC_W'(1);
  end

  logic psen_ok;
  always_comb begin
    psen_ok = ((int'(phase) >= PSEN_OFF) && (int'(phase) < PSEN_OFF + PSEN_W)) ||
              ((int'(phase) >= HALF + PSEN_OFF) && (int'(phase) < HALF + PSEN_OFF + PSEN_W));
  end

  assert_phase_range_R1: assert property (@(posedge clk) disable iff (!arst_n)
    int'(phase) < CYC_LEN);

  assert_phase_wrap_R1: assert property (@(posedge clk) disable iff (!arst_n || sync_rst)
    (phase == PH_W'(CYC_LEN - 1)) |=> (phase == '0));

  assert_ale_rise_R2: assert property (@(posedge clk) disable iff (!arst_n || sync_rst)
    $rose(ale) |-> (phase == '0 || phase == PH_W'(HALF)));

  assert_psen_window_R3: assert property (@(posedge clk) disable iff (!arst_n || sync_rst)
    !psen_n |-> psen_ok);

  assert_qual_len_R8: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(sync_rst) |-> (hi_cnt >= HC_W'(QUAL_CLKS)));

  assert_release_R9: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(sync_rst) |-> !$past(rst_pin, 3));

  assert_reset_hold_R10: assert property (@(posedge clk) disable iff (!arst_n)
    sync_rst |-> (phase == '0 && ale && psen_n));

  assert_no_overlap_R11: assert property (@(posedge clk) disable iff (!arst_n || sync_rst)
    !(ale && !psen_n));
endmodule

bind bus_strobe_seq bus_strobe_seq_chk #(
  .CYC_LEN    (CYC_LEN),
  .QUAL_CYCLES(QUAL_CYCLES),
  .PSEN_W     (PSEN_W),
  .PSEN_OFF   (PSEN_OFF)
) u_chk (
  .clk      (clk),
  .arst_n   (arst_n),
  .rst_pin  (rst_pin),
  .ale      (ale),
  .psen_n   (psen_n),
  .phase    (phase),
  .sync_rst (sync_rst)
);

// File: tb/bus_strobe_seq_test.sv
`timescale 1ns/1ps
module bus_strobe_seq_test;
  logic       clk = 1'b0;
  logic       arst_n, rst_pin, ext_exec, latch_off, data_req;
  logic       ale, psen_n, sync_rst;
  logic [3:0] phase;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;

  bus_strobe_seq uut (
    .clk(clk), .arst_n(arst_n), .rst_pin(rst_pin), .ext_exec(ext_exec),
    .latch_off(latch_off), .data_req(data_req), .ale(ale), .psen_n(psen_n),
    .phase(phase), .sync_rst(sync_rst)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d at t=%0t", req, what, act, exp, $time);
    end
  endtask

  // expected strobes from the requirements
  function automatic bit exp_ale(int k, bit d, bit off, bit ext);
    bit held = off && !ext;                      // R6, R7
    if (held) return d ? (k < 2) : 1'b1;         // R6
    return (k < 2) || ((k == 6 || k == 7) && !d); // R2, R4
  endfunction

  function automatic bit exp_psen_n(int k, bit d, bit ext);
    bit win = (k >= 3 && k <= 5) || (k >= 9 && k <= 11);
    return !(ext && !d && win);                  // R3, R4
  endfunction

  task automatic align();
    for (int i = 0; i < 20 && phase != 4'd11; i++) @(negedge clk);
  endtask

  // one machine cycle; optionally change the inputs after phase 2 (R5)
  task automatic run_cycle(input bit d, input bit off, input bit ext,
                           input string req, input bit flip);
    align();
    data_req = d; latch_off = off; ext_exec = ext;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      check(phase == 4'(k), "R1", {req, " phase"}, phase, k);
      check(ale == exp_ale(k, d, off, ext), req, $sformatf("ale ph%0d", k),
            ale, exp_ale(k, d, off, ext));
      check(psen_n == exp_psen_n(k, d, ext), req, $sformatf("psen_n ph%0d", k),
            psen_n, exp_psen_n(k, d, ext));
      if (flip && k == 2) begin
        data_req = !d; latch_off = !off; ext_exec = !ext;
      end
    end
  endtask

  task automatic t_normal();
    run_cycle(0, 0, 0, "R2", 0);
    run_cycle(0, 0, 0, "R2", 0);
  endtask

  task automatic t_fetch();
    run_cycle(0, 0, 1, "R3", 0);
    run_cycle(0, 0, 1, "R3", 0);
  endtask

  task automatic t_data();
    run_cycle(1, 0, 1, "R4", 0);
    run_cycle(1, 0, 0, "R4", 0);
    run_cycle(0, 0, 1, "R4", 0);
  endtask

  task automatic t_latch_off();
    run_cycle(0, 1, 0, "R6", 0);
    run_cycle(1, 1, 0, "R6", 0);
    run_cycle(0, 1, 0, "R6", 0);
  endtask

  task automatic t_override();
    run_cycle(0, 1, 1, "R7", 0);
    run_cycle(1, 1, 1, "R7", 0);
  endtask

  task automatic t_sample_point();
    run_cycle(0, 0, 1, "R5", 1);   // inputs flip mid-cycle: no effect yet
    run_cycle(1, 1, 0, "R5", 0);   // flipped values take hold next cycle
  endtask

  task automatic t_reset();
    bit seen;
    // short pulse must be ignored (R8)
    @(negedge clk);
    rst_pin = 1'b1;
    seen = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (sync_rst) seen = 1; end
    rst_pin = 1'b0;
    for (int i = 0; i < 3; i++) begin @(negedge clk); if (sync_rst) seen = 1; end
    check(!seen, "R8", "short pulse asserted sync_rst", seen, 0);
    // full qualification, count restarted
    rst_pin = 1'b1;
    for (int i = 1; i <= 26; i++) begin
      @(negedge clk);
      if (i == 25) check(!sync_rst, "R8", "sync_rst before edge 26", sync_rst, 0);
      if (i == 26) check(sync_rst, "R8", "sync_rst at edge 26", sync_rst, 1);
    end
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(phase == 4'd0 && ale && psen_n, "R10", "outputs held in reset",
            {phase, ale, psen_n}, 3);
    end
    // release (R9)
    rst_pin = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(sync_rst, "R9", "sync_rst after 2 edges", sync_rst, 1);
    @(negedge clk);
    check(!sync_rst, "R9", "sync_rst after 3 edges", sync_rst, 0);
    check(phase == 4'd0, "R9", "phase at release", phase, 0);
    @(negedge clk);
    check(phase == 4'd1, "R9", "phase after release", phase, 1);
  endtask

  initial begin
    arst_n = 1'b0; rst_pin = 1'b0; ext_exec = 1'b0; latch_off = 1'b0; data_req = 1'b0;
    repeat (3) @(negedge clk);
    check(phase == 4'd0 && psen_n && !sync_rst, "R10", "power-on state",
          {phase, psen_n, sync_rst}, 2);
    arst_n = 1'b1;
    t_reset();
    t_normal();
    t_fetch();
    t_data();
    t_latch_off();
    t_override();
    t_sample_point();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule